// File: doc/BRIEF.md
# Packed Default Attribute Loader

This block sits on a register-write path and turns a stream of 32-bit words into attribute vectors. Each vector has four 24-bit float components and arrives as three words. The block collects the words and splits them into components, which come out in reversed order. It then sends the vector to one of two places, chosen by a self-incrementing attribute index. While the index is below 15, each vector fills the next entry of a 15-entry default-attribute table, which can be read at any time. Once the index reaches 15, vectors fill the slots of an immediate input vertex instead. When the last configured slot is filled, the vertex is offered downstream on a valid/ready output.

Software first programs the attribute index through a configuration address, then writes the data words. A one-cycle pipeline-reset request is held until the next immediate vertex goes out, and is flagged on that vertex. The block does no floating-point arithmetic; components are carried as raw 24-bit patterns.

Top module: `attr_pack_loader`

## Requirements
- R1: After reset, wr_ready is 1, out_valid is 0, index_err is 0, attr_index is 0 and every table entry reads as zero.
- R2: A write is accepted when wr_en and wr_ready are both 1 at a clock edge. Data words go to address 0x233, 0x234 or 0x235, and the three are interchangeable: words are placed by arrival order only. A vector is processed only on the edge that accepts its third word, after which the word count restarts.
- R3: With words a, b and c in arrival order, the components are w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]} and x = c[23:0]. A vector is presented as 96 bits {w, z, y, x}, with w in [95:72] and x in [23:0].
- R4: When a vector completes with attr_index below 15, it is written to table entry attr_index, and attr_index goes up by one at the same edge.
- R5: When a vector completes with attr_index of 16 or more, it is dropped. index_err is 1 for exactly the next cycle, and attr_index is unchanged.
- R6: When a vector completes with attr_index equal to 15, it is written into the current immediate slot k, found at out_vertex[k*96 +: 96]. If k is below max_slot, k goes up by one. Otherwise k returns to 0 and out_valid is 1 from the next cycle. attr_index stays at 15.
- R7: A write to address 0x232 loads attr_index from wr_data[4:0] and discards any partly gathered vector.
- R8: While out_valid is 1 and out_ready is 0, out_valid and out_vertex hold their values and wr_ready is 0. While wr_ready is 0, no write of any kind has an effect.
- R9: A one-cycle pulse on pipe_rst_req is held pending. The first immediate vertex completed after it carries out_pipe_reset = 1, and completing that vertex clears the pending request. Later vertices carry 0 until a new pulse arrives.
- R10: A rd_addr of 15 or more reads as zero. rd_data is a combinational read of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 32 | Register write data |
| wr_ready | output | 1 | Writes are accepted while high |
| max_slot | input | 3 | Highest immediate slot of a vertex |
| pipe_rst_req | input | 1 | Pipeline-reset request pulse |
| rd_addr | input | 4 | Default-table read entry |
| rd_data | output | 96 | Default-table read vector {w,z,y,x} |
| attr_index | output | 5 | Current attribute index |
| index_err | output | 1 | One-cycle pulse when a vector is dropped |
| out_valid | output | 1 | Immediate vertex available |
| out_ready | input | 1 | Downstream accepts the vertex |
| out_vertex | output | 768 | Immediate vertex, 8 slots of 96 bits |
| out_pipe_reset | output | 1 | Pipeline-reset flag carried with the vertex |

## Verification
The edge that accepts the third word is the one that acts on the vector. The table entry and attr_index therefore change at that edge, and the bench reads them just after it. index_err and a new out_valid appear in the cycle after that edge. A monitor samples the output handshake at falling edges and compares each vertex taken against a queue, filled by the driver before it sends the last word. Checks for stalls and partial vectors read the ports only between writes, so every value checked has settled.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int COMP_W = 24;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 4 * COMP_W;

  typedef struct packed {
    logic [COMP_W-1:0] w;
    logic [COMP_W-1:0] z;
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] x;
  } attr_vec_t;

  // Split three arrival-ordered words into the four components.
  function automatic attr_vec_t split_words(input logic [WORD_W-1:0] a,
                                            input logic [WORD_W-1:0] b,
                                            input logic [WORD_W-1:0] c);
    attr_vec_t v;
    v.w = a[31:8];
    v.z = {a[7:0], b[31:16]};
    v.y = {b[15:0], c[31:24]};
    v.x = c[23:0];
    return v;
  endfunction
endpackage

// File: rtl/attr_word_collector.sv
module attr_word_collector
  import attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              clear,
  input  logic [WORD_W-1:0] data,
  output logic              done,
  output attr_vec_t         vec
);
  localparam logic [1:0] LAST = 2'd2;

  logic [1:0]        cnt_q, cnt_d;
  logic [WORD_W-1:0] w0_q, w1_q;
  logic              w0_en, w1_en;

  always_comb begin
    w0_en = take && (cnt_q == 2'd0);
    w1_en = take && (cnt_q == 2'd1);
    cnt_d = cnt_q;
    if (clear)     cnt_d = 2'd0;
    else if (take) cnt_d = (cnt_q == LAST) ? 2'd0 : cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     w0_q <= '0;
    else if (w0_en) w0_q <= data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     w1_q <= '0;
    else if (w1_en) w1_q <= data;
  end

  assign done = take && (cnt_q == LAST);
  assign vec  = split_words(w0_q, w1_q, data);

  // R2
  restart_after_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == 2'd0));
endmodule

// File: rtl/attr_default_table.sv
module attr_default_table
  import attr_pkg::*;
#(
  parameter int ENTRIES = 15,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  attr_vec_t     wvec,
  input  logic [AW-1:0] raddr,
  output attr_vec_t     rvec
);
  localparam logic [AW-1:0] TOP = AW'(ENTRIES - 1);

  attr_vec_t mem_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic en;
    assign en = we && (waddr == AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[e] <= '0;
      else if (en) mem_q[e] <= wvec;
    end
  end

  always_comb begin
    rvec = '0;
    if (raddr <= TOP) rvec = mem_q[raddr];
  end

  // R4
  table_addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr <= TOP));
endmodule

// File: rtl/attr_imm_assembler.sv
module attr_imm_assembler
  import attr_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_we,
  input  attr_vec_t          slot_vec,
  input  logic [SW-1:0]      max_slot,
  input  logic               rst_req,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [SLOTS*VEC_W-1:0] out_vertex,
  output logic               out_pipe_reset
);
  logic [SW-1:0] slot_q, slot_d;
  logic          emit;
  logic          valid_q, valid_d;
  logic          pend_q, pend_d;
  logic          flag_q, flag_d;
  attr_vec_t     slot_mem_q [SLOTS];

  always_comb begin
    emit    = slot_we && (slot_q >= max_slot);
    slot_d  = slot_q;
    if (slot_we) slot_d = emit ? '0 : slot_q + SW'(1);
    valid_d = emit ? 1'b1 : (valid_q && !out_ready);
    pend_d  = emit ? rst_req : (pend_q || rst_req);
    flag_d  = emit ? pend_q : flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      slot_q  <= slot_d;
      valid_q <= valid_d;
      pend_q  <= pend_d;
      flag_q  <= flag_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic en;
    assign en = slot_we && (slot_q == SW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_mem_q[s] <= '0;
      else if (en) slot_mem_q[s] <= slot_vec;
    end
    assign out_vertex[s*VEC_W +: VEC_W] = slot_mem_q[s];
  end

  assign out_valid      = valid_q;
  assign out_pipe_reset = flag_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(out_vertex) && $stable(flag_q)));

  // R8
  no_fill_while_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |-> !slot_we);

  // R9
  pend_clear_on_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $rose(valid_q));
endmodule

// File: rtl/attr_pack_loader.sv
module attr_pack_loader
  import attr_pkg::*;
#(
  parameter int                ADDR_W     = 10,
  parameter int                IDX_W      = 5,
  parameter int                ENTRIES    = 15,
  parameter int                SLOTS      = 8,
  parameter int                TAW        = $clog2(ENTRIES + 1),
  parameter int                SW         = $clog2(SLOTS),
  parameter logic [ADDR_W-1:0] CFG_ADDR   = 10'h232,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 10'h233
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  output logic                   wr_ready,
  input  logic [SW-1:0]          max_slot,
  input  logic                   pipe_rst_req,
  input  logic [TAW-1:0]         rd_addr,
  output logic [95:0]            rd_data,
  output logic [IDX_W-1:0]       attr_index,
  output logic                   index_err,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [SLOTS*96-1:0]    out_vertex,
  output logic                   out_pipe_reset
);
  localparam logic [IDX_W-1:0]  IMM_IDX   = IDX_W'(ENTRIES);
  localparam logic [ADDR_W-1:0] DATA_LAST = DATA_BASE + ADDR_W'(2);

  logic             accept, data_hit, cfg_hit;
  logic             vec_done;
  attr_vec_t        vec;
  logic             tbl_we, imm_we, drop;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q;
  attr_vec_t        rvec;

  assign wr_ready = !(out_valid && !out_ready);
  assign accept   = wr_en && wr_ready;
  assign data_hit = accept && (wr_addr >= DATA_BASE) && (wr_addr <= DATA_LAST);
  assign cfg_hit  = accept && (wr_addr == CFG_ADDR);

  attr_word_collector i_collect (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (data_hit),
    .clear (cfg_hit),
    .data  (wr_data),
    .done  (vec_done),
    .vec   (vec)
  );

  always_comb begin
    tbl_we = vec_done && (idx_q < IMM_IDX);
    imm_we = vec_done && (idx_q == IMM_IDX);
    drop   = vec_done && (idx_q > IMM_IDX);
    idx_d  = idx_q;
    if (cfg_hit)     idx_d = wr_data[IDX_W-1:0];
    else if (tbl_we) idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      err_q <= drop;
    end
  end

  attr_default_table #(.ENTRIES(ENTRIES), .AW(TAW)) i_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (idx_q[TAW-1:0]),
    .wvec  (vec),
    .raddr (rd_addr),
    .rvec  (rvec)
  );

  attr_imm_assembler #(.SLOTS(SLOTS), .SW(SW)) i_imm (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_we        (imm_we),
    .slot_vec       (vec),
    .max_slot       (max_slot),
    .rst_req        (pipe_rst_req),
    .out_ready      (out_ready),
    .out_valid      (out_valid),
    .out_vertex     (out_vertex),
    .out_pipe_reset (out_pipe_reset)
  );

  assign rd_data    = rvec;
  assign attr_index = idx_q;
  assign index_err  = err_q;

  // R4
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_done && (idx_q < IMM_IDX)) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R5
  drop_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_done && (idx_q > IMM_IDX)) |=> (index_err && $stable(idx_q)));

  // R6
  imm_index_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_done && (idx_q == IMM_IDX)) |=> (idx_q == IMM_IDX));
endmodule

// File: tb/test_attr_pack_loader.sv
module test_attr_pack_loader;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en;
  logic [9:0]         wr_addr;
  logic [31:0]        wr_data;
  logic               wr_ready;
  logic [2:0]         max_slot;
  logic               pipe_rst_req;
  logic [3:0]         rd_addr;
  logic [95:0]        rd_data;
  logic [4:0]         attr_index;
  logic               index_err;
  logic               out_valid;
  logic               out_ready;
  logic [SLOTS*96-1:0] out_vertex;
  logic               out_pipe_reset;

  attr_pack_loader i_attr_pack_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .max_slot(max_slot), .pipe_rst_req(pipe_rst_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .attr_index(attr_index),
    .index_err(index_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_vertex(out_vertex), .out_pipe_reset(out_pipe_reset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [SLOTS*96-1:0] vtx;
    int                  top;
    logic                rflag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   err_seen = 0;
  int   cycles = 0;

  function automatic logic [95:0] expect_vec(input logic [31:0] a, b, c);
    logic [23:0] w, z, y, x;
    w = a >> 8;
    z = {a[7:0], b[31:16]};
    y = {b[15:0], c[31:24]};
    x = c[23:0];
    return {w, z, y, x};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compares each vertex taken against the queue
  always @(negedge clk) begin
    cycles++;
    if (index_err) err_seen++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected vertex", out_vertex[95:0], '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        for (int s = 0; s <= e.top; s++)
          chk(out_vertex[s*96 +: 96] == e.vtx[s*96 +: 96], "R6 vertex slot",
              out_vertex[s*96 +: 96], e.vtx[s*96 +: 96]);
        chk(out_pipe_reset == e.rflag, "R9 reset flag", 96'(out_pipe_reset), 96'(e.rflag));
      end
    end
  end

  // watchdog
  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    summary();
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic send_vec(input logic [31:0] a, b, c);
    wr(10'h233, a); wr(10'h234, b); wr(10'h235, c);
  endtask

  task automatic set_index(input logic [4:0] v);
    wr(10'h232, {27'd0, v});
  endtask

  initial begin
    logic [95:0] va, vb, vd, vq;
    exp_t e;
    int base;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    max_slot = '0; pipe_rst_req = 1'b0; rd_addr = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready == 1'b1, "R1 wr_ready", 96'(wr_ready), 96'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 96'(out_valid), 96'd0);
    chk(attr_index == 5'd0, "R1 attr_index", 96'(attr_index), 96'd0);
    chk(index_err == 1'b0, "R1 index_err", 96'(index_err), 96'd0);
    chk(rd_data == '0, "R1 table", rd_data, '0);
    @(posedge clk); #1;

    // R3 R4 first vector into entry 0
    va = expect_vec(32'h12345678, 32'h9ABCDEF0, 32'h0FEDCBA9);
    send_vec(32'h12345678, 32'h9ABCDEF0, 32'h0FEDCBA9);
    rd_addr = 4'd0; #1;
    chk(rd_data == va, "R3 unpack entry0", rd_data, va);
    chk(attr_index == 5'd1, "R4 index step", 96'(attr_index), 96'd1);

    // R2 mixed addresses, nothing before third word
    vb = expect_vec(32'hA1B2C3D4, 32'h55667788, 32'hFF00EE11);
    wr(10'h235, 32'hA1B2C3D4);
    wr(10'h235, 32'h55667788);
    rd_addr = 4'd1; #1;
    chk(rd_data == '0, "R2 partial not stored", rd_data, '0);
    chk(attr_index == 5'd1, "R2 partial index", 96'(attr_index), 96'd1);
    wr(10'h233, 32'hFF00EE11);
    #1;
    chk(rd_data == vb, "R2 any data address", rd_data, vb);
    chk(attr_index == 5'd2, "R4 index step 2", 96'(attr_index), 96'd2);

    // R7 config write discards partial vector
    wr(10'h233, 32'h11111111);
    wr(10'h234, 32'h22222222);
    set_index(5'd5);
    chk(attr_index == 5'd5, "R7 index load", 96'(attr_index), 96'd5);
    vd = expect_vec(32'hCAFEF00D, 32'hDEADBEEF, 32'h01234567);
    send_vec(32'hCAFEF00D, 32'hDEADBEEF, 32'h01234567);
    rd_addr = 4'd5; #1;
    chk(rd_data == vd, "R7 fresh vector after load", rd_data, vd);
    rd_addr = 4'd2; #1;
    chk(rd_data == '0, "R7 partial discarded", rd_data, '0);

    // R10 out-of-range read
    rd_addr = 4'd15; #1;
    chk(rd_data == '0, "R10 read beyond table", rd_data, '0);

    // R5 drop when index >= 16
    base = err_seen;
    set_index(5'd16);
    send_vec(32'h01010101, 32'h02020202, 32'h03030303);
    repeat (2) @(posedge clk); #1;
    chk(err_seen == base + 1, "R5 error pulse", 96'(err_seen - base), 96'd1);
    chk(attr_index == 5'd16, "R5 index unchanged", 96'(attr_index), 96'd16);
    set_index(5'd31);
    send_vec(32'h04040404, 32'h05050505, 32'h06060606);
    repeat (2) @(posedge clk); #1;
    chk(err_seen == base + 2, "R5 error pulse 31", 96'(err_seen - base), 96'd2);
    chk(out_valid == 1'b0, "R5 no vertex", 96'(out_valid), 96'd0);

    // R6 immediate vertex with three slots
    max_slot = 3'd2;
    set_index(5'd15);
    e.vtx = '0; e.top = 2; e.rflag = 1'b0;
    e.vtx[0*96 +: 96] = expect_vec(32'h10000001, 32'h20000002, 32'h30000003);
    e.vtx[1*96 +: 96] = expect_vec(32'h40000004, 32'h50000005, 32'h60000006);
    e.vtx[2*96 +: 96] = expect_vec(32'h70000007, 32'h80000008, 32'h90000009);
    send_vec(32'h10000001, 32'h20000002, 32'h30000003);
    send_vec(32'h40000004, 32'h50000005, 32'h60000006);
    chk(out_valid == 1'b0, "R6 no early emit", 96'(out_valid), 96'd0);
    exp_q.push_back(e);
    send_vec(32'h70000007, 32'h80000008, 32'h90000009);
    repeat (2) @(posedge clk); #1;
    chk(attr_index == 5'd15, "R6 index stays", 96'(attr_index), 96'd15);

    // R6 single-slot vertices, R9 reset flag
    max_slot = 3'd0;
    pipe_rst_req = 1'b1; @(posedge clk); #1; pipe_rst_req = 1'b0;
    e.vtx = '0; e.top = 0; e.rflag = 1'b1;
    e.vtx[95:0] = expect_vec(32'hAAAA5555, 32'h5555AAAA, 32'h0F0F0F0F);
    exp_q.push_back(e);
    send_vec(32'hAAAA5555, 32'h5555AAAA, 32'h0F0F0F0F);
    e.rflag = 1'b0;
    e.vtx[95:0] = expect_vec(32'h13579BDF, 32'h2468ACE0, 32'hF0E1D2C3);
    exp_q.push_back(e);
    send_vec(32'h13579BDF, 32'h2468ACE0, 32'hF0E1D2C3);
    repeat (2) @(posedge clk); #1;

    // R8 stall
    out_ready = 1'b0;
    vq = expect_vec(32'h76543210, 32'hFEDCBA98, 32'h89ABCDEF);
    e.vtx = '0; e.vtx[95:0] = vq; e.rflag = 1'b0;
    exp_q.push_back(e);
    send_vec(32'h76543210, 32'hFEDCBA98, 32'h89ABCDEF);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid held", 96'(out_valid), 96'd1);
    chk(wr_ready == 1'b0, "R8 wr_ready low", 96'(wr_ready), 96'd0);
    chk(out_vertex[95:0] == vq, "R8 data held", out_vertex[95:0], vq);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 10'h233; wr_data = 32'hBADBAD00;
    repeat (2) @(posedge clk); #1;
    wr_addr = 10'h232; wr_data = 32'd3;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
    chk(out_vertex[95:0] == vq, "R8 data held later", out_vertex[95:0], vq);
    chk(attr_index == 5'd15, "R8 blocked config write", 96'(attr_index), 96'd15);
    @(posedge clk); #1;
    out_ready = 1'b1;
    repeat (2) @(posedge clk); #1;
    vq = expect_vec(32'h0BADF00D, 32'h600DCAFE, 32'h12121212);
    e.vtx[95:0] = vq;
    exp_q.push_back(e);
    send_vec(32'h0BADF00D, 32'h600DCAFE, 32'h12121212);
    repeat (3) @(posedge clk); #1;

    chk(exp_q.size() == 0, "R6 all vertices seen", 96'(exp_q.size()), 96'd0);
    summary();
  end
endmodule